// File: doc/BRIEF.md
# Time-Triggered Transmit Queue Dispatcher

The dispatcher holds frames that software has lined up for time-triggered transmission. Each virtual link (VL) has its own first-in first-out queue. Every entry holds a buffer address and a frame length. Software configures how many frames each VL may hold. That depth is the number of frames the VL can send in one cluster cycle, which is the cluster cycle length divided by the VL period.

A schedule sequencer outside the block raises a slot tick together with the VL that owns the slot. If the local clock has been corrected and that VL's queue holds an entry, the block presents the head entry on a valid/ready send interface toward the MAC. The entry leaves the queue only when the MAC accepts it. When a slot finds its queue empty, or finds the send port still busy with an earlier request, the slot is lost and a saturating per-VL miss counter rises. Enqueue requests are answered in the same cycle with accept or reject.

Top module: `tt_tx_dispatch`

## Requirements
- R1: After reset, tx_valid is low, every miss counter reads zero, every queue is empty, and every VL depth equals MAX_DEPTH.
- R2: An enqueue (enq_valid high) to a VL whose entry count is below its configured depth raises enq_accept in the same cycle. enq_reject stays low and the entry is stored. enq_accept and enq_reject are never high together.
- R3: An enqueue to a VL whose queue is full raises enq_reject with enq_accept low, and the queue contents stay unchanged. A VL configured with depth 0 rejects every enqueue.
- R4: Within one VL, entries are sent in the order they were accepted.
- R5: A slot_tick with sync_ok high, naming a VL whose queue is not empty while no request is outstanding, raises tx_valid on the following cycle. tx_addr, tx_len and tx_vl then carry that VL's head entry.
- R6: While tx_valid is high and tx_ready is low, tx_valid, tx_addr, tx_len and tx_vl hold steady. The entry is removed only in the cycle tx_ready is high, and tx_valid is low in the next cycle.
- R7: A slot_tick with sync_ok high, naming a VL whose queue is empty, produces no request. It raises that VL's miss counter by one, and the counter saturates at its all-ones value.
- R8: slot_tick while sync_ok is low is ignored: no request and no change to any miss counter.
- R9: A slot_tick with sync_ok high that arrives while a request is outstanding does not change the outstanding request. It raises the miss counter of the VL it names, and that VL's queue is left intact.
- R10: cfg_load replaces every VL depth with its field of cfg_depth, clamped to MAX_DEPTH. Field v occupies bits [v*DEPTH_W +: DEPTH_W]. The same cfg_load empties all queues, clears all miss counters, drops any outstanding request and rejects an enqueue in the same cycle.
- R11: Queues are independent: entries enqueued to one VL never appear on a slot of another VL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load per-VL depths; clears queues and counters |
| cfg_depth | input | NUM_VL*DEPTH_W | Per-VL depth fields, VL v at bits v*DEPTH_W |
| sync_ok | input | 1 | Local clock corrected; slots may be served |
| enq_valid | input | 1 | Enqueue request |
| enq_vl | input | VL_W | Target VL of the enqueue |
| enq_addr | input | ADDR_W | Frame buffer address |
| enq_len | input | LEN_W | Frame length |
| enq_accept | output | 1 | Enqueue stored (same cycle) |
| enq_reject | output | 1 | Enqueue refused (same cycle) |
| slot_tick | input | 1 | Send slot begins |
| slot_vl | input | VL_W | VL owning the slot |
| tx_valid | output | 1 | Send request to MAC |
| tx_ready | input | 1 | MAC accepts the request |
| tx_addr | output | ADDR_W | Address of the frame to send |
| tx_len | output | LEN_W | Length of the frame to send |
| tx_vl | output | VL_W | VL of the frame to send |
| miss_count | output | NUM_VL*MISS_W | Per-VL lost-slot counters, VL v at bits v*MISS_W |

## Verification
A queue pointer that wraps at the wrong depth shows up first as a wrong accept or reject at the configured boundary. It shows up later as a tx_addr out of order on the next slot of that VL. A stale count is seen within one tick, either as a send request where a miss was due or as a miss counter rising against a loaded queue. A fault in the outstanding-request state is visible in the cycle after a tick or handshake: tx_valid fails to drop after tx_ready, or a second tick disturbs the held request.

// File: rtl/ttd_pkg.sv
package ttd_pkg;
  localparam int ADDR_W = 16;
  localparam int LEN_W  = 11;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  len;
  } tx_entry_t;
endpackage

// File: rtl/ttd_vl_fifo.sv
module ttd_vl_fifo
  import ttd_pkg::*;
#(
  parameter int MAX_DEPTH = 4,
  parameter int DEPTH_W   = $clog2(MAX_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic [DEPTH_W-1:0] depth,
  input  logic               push,
  input  tx_entry_t          push_entry,
  input  logic               pop,
  output tx_entry_t          head,
  output logic               empty,
  output logic               full
);
  localparam int PTR_W = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1;

  tx_entry_t          store [MAX_DEPTH];
  logic [PTR_W-1:0]   rd_q, rd_d, wr_q, wr_d;
  logic [DEPTH_W-1:0] cnt_q, cnt_d;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p,
                                            input logic [DEPTH_W-1:0] lim);
    if (DEPTH_W'(p) + DEPTH_W'(1) >= lim) step = '0;
    else                                  step = p + PTR_W'(1);
  endfunction

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q >= depth);
  assign head  = store[rd_q];

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (clear) begin
      rd_d  = '0;
      wr_d  = '0;
      cnt_d = '0;
    end else begin
      if (push) wr_d = step(wr_q, depth);
      if (pop)  rd_d = step(rd_q, depth);
      if (push && !pop)      cnt_d = cnt_q + DEPTH_W'(1);
      else if (pop && !push) cnt_d = cnt_q - DEPTH_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clear) store[wr_q] <= push_entry;
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= DEPTH_W'(MAX_DEPTH));
endmodule

// File: rtl/ttd_miss_ctr.sv
module ttd_miss_ctr #(
  parameter int MISS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              inc,
  output logic [MISS_W-1:0] count
);
  logic [MISS_W-1:0] cnt_d;

  always_comb begin
    cnt_d = count;
    if (clear)                cnt_d = '0;
    else if (inc && !(&count)) cnt_d = count + MISS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= cnt_d;
  end

  assert_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (&count) && !clear |=> (&count));
endmodule

// File: rtl/tt_tx_dispatch.sv
module tt_tx_dispatch
  import ttd_pkg::*;
#(
  parameter int NUM_VL    = 4,
  parameter int MAX_DEPTH = 4,
  parameter int MISS_W    = 8,
  parameter int VL_W      = (NUM_VL > 1) ? $clog2(NUM_VL) : 1,
  parameter int DEPTH_W   = $clog2(MAX_DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_load,
  input  logic [NUM_VL*DEPTH_W-1:0] cfg_depth,
  input  logic                      sync_ok,
  input  logic                      enq_valid,
  input  logic [VL_W-1:0]           enq_vl,
  input  logic [ADDR_W-1:0]         enq_addr,
  input  logic [LEN_W-1:0]          enq_len,
  output logic                      enq_accept,
  output logic                      enq_reject,
  input  logic                      slot_tick,
  input  logic [VL_W-1:0]           slot_vl,
  output logic                      tx_valid,
  input  logic                      tx_ready,
  output logic [ADDR_W-1:0]         tx_addr,
  output logic [LEN_W-1:0]          tx_len,
  output logic [VL_W-1:0]           tx_vl,
  output logic [NUM_VL*MISS_W-1:0]  miss_count
);
  logic [DEPTH_W-1:0] depth_q [NUM_VL];
  logic [NUM_VL-1:0]  q_empty, q_full, q_push, q_pop, q_miss;
  tx_entry_t          q_head [NUM_VL];
  tx_entry_t          in_entry;
  logic               busy_q, busy_d;
  logic [VL_W-1:0]    act_q, act_d;
  logic               tick_live, start;
  logic               enq_in_range, slot_in_range;

  assign in_entry      = '{addr: enq_addr, len: enq_len};
  assign enq_in_range  = (32'(enq_vl) < NUM_VL);
  assign slot_in_range = (32'(slot_vl) < NUM_VL);
  assign tick_live     = slot_tick && sync_ok && slot_in_range && !cfg_load;

  always_comb begin
    enq_accept = enq_valid && enq_in_range && !cfg_load && !q_full[enq_vl];
    enq_reject = enq_valid && !enq_accept;
    start      = tick_live && !busy_q && !q_empty[slot_vl];
    busy_d     = busy_q;
    act_d      = act_q;
    if (cfg_load) begin
      busy_d = 1'b0;
    end else if (start) begin
      busy_d = 1'b1;
      act_d  = slot_vl;
    end else if (busy_q && tx_ready) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      act_q  <= '0;
    end else begin
      busy_q <= busy_d;
      act_q  <= act_d;
    end
  end

  genvar v;
  generate
    for (v = 0; v < NUM_VL; v++) begin : g_vl
      logic [DEPTH_W-1:0] depth_field;
      assign depth_field = cfg_depth[v*DEPTH_W +: DEPTH_W];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          depth_q[v] <= DEPTH_W'(MAX_DEPTH);
        else if (cfg_load)
          depth_q[v] <= (depth_field > DEPTH_W'(MAX_DEPTH)) ? DEPTH_W'(MAX_DEPTH)
                                                            : depth_field;
      end

      assign q_push[v] = enq_accept && (32'(enq_vl) == v);
      assign q_pop[v]  = busy_q && tx_ready && !cfg_load && (32'(act_q) == v);
      assign q_miss[v] = tick_live && (32'(slot_vl) == v) && (busy_q || q_empty[v]);

      ttd_vl_fifo #(.MAX_DEPTH(MAX_DEPTH), .DEPTH_W(DEPTH_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clear(cfg_load), .depth(depth_q[v]),
        .push(q_push[v]), .push_entry(in_entry), .pop(q_pop[v]),
        .head(q_head[v]), .empty(q_empty[v]), .full(q_full[v]));

      ttd_miss_ctr #(.MISS_W(MISS_W)) u_miss (
        .clk(clk), .rst_n(rst_n), .clear(cfg_load), .inc(q_miss[v]),
        .count(miss_count[v*MISS_W +: MISS_W]));
    end
  endgenerate

  assign tx_valid = busy_q;
  assign tx_vl    = act_q;
  assign tx_addr  = q_head[act_q].addr;
  assign tx_len   = q_head[act_q].len;

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !cfg_load |=>
      tx_valid && $stable(tx_addr) && $stable(tx_len) && $stable(tx_vl));
  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_valid);
  assert_unsynced_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid && !sync_ok |=> !tx_valid);
  assert_enq_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(enq_accept && enq_reject));
  assert_cfg_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> !tx_valid);
endmodule

// File: tb/sim_tt_tx_dispatch.sv
module sim_tt_tx_dispatch;
  localparam int NV = 4, MD = 4, MW = 8, VW = 2, DW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_load = 0;
  logic [NV*DW-1:0] cfg_depth = '0;
  logic sync_ok = 0, enq_valid = 0, slot_tick = 0, tx_ready = 0;
  logic [VW-1:0] enq_vl = '0, slot_vl = '0;
  logic [15:0] enq_addr = '0;
  logic [10:0] enq_len = '0;
  logic enq_accept, enq_reject, tx_valid;
  logic [15:0] tx_addr;
  logic [10:0] tx_len;
  logic [VW-1:0] tx_vl;
  logic [NV*MW-1:0] miss_count;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  tt_tx_dispatch #(.NUM_VL(NV), .MAX_DEPTH(MD), .MISS_W(MW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_depth(cfg_depth),
    .sync_ok(sync_ok), .enq_valid(enq_valid), .enq_vl(enq_vl),
    .enq_addr(enq_addr), .enq_len(enq_len), .enq_accept(enq_accept),
    .enq_reject(enq_reject), .slot_tick(slot_tick), .slot_vl(slot_vl),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_addr(tx_addr),
    .tx_len(tx_len), .tx_vl(tx_vl), .miss_count(miss_count));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [MW-1:0] miss(input int v);
    return miss_count[v*MW +: MW];
  endfunction

  task automatic enq(input int vl, input int addr, input int len, input bit ok, input string req);
    @(negedge clk);
    enq_valid = 1; enq_vl = VW'(vl); enq_addr = 16'(addr); enq_len = 11'(len);
    #1;
    chk(req, {enq_accept, enq_reject}, {30'd0, ok, !ok});
    @(negedge clk);
    enq_valid = 0;
  endtask

  task automatic tick(input int vl);
    @(negedge clk);
    slot_tick = 1; slot_vl = VW'(vl);
    @(negedge clk);
    slot_tick = 0;
  endtask

  task automatic serve(input int vl, input int addr, input int len, input string req);
    chk(req, {tx_valid, 13'd0, tx_vl, tx_addr}, {1'b1, 13'd0, VW'(vl), 16'(addr)});
    chk(req, tx_len, len);
    tx_ready = 1;
    @(negedge clk);
    tx_ready = 0;
    chk("R6 release", tx_valid, 0);
  endtask

  task automatic load(input int d0, input int d1, input int d2, input int d3);
    @(negedge clk);
    cfg_load = 1;
    cfg_depth = {DW'(d3), DW'(d2), DW'(d1), DW'(d0)};
    @(negedge clk);
    cfg_load = 0;
  endtask

  task automatic t_reset;
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 miss", miss_count, 0);
    for (int i = 0; i < MD; i++) enq(0, 16'h100 + i, 60 + i, 1, "R1 default depth");
    enq(0, 16'h1ff, 1, 0, "R1 default depth full");
    sync_ok = 1;
    for (int i = 0; i < MD; i++) begin
      tick(0);
      serve(0, 16'h100 + i, 60 + i, "R4 order default");
    end
    chk("R1 no miss", miss(0), 0);
  endtask

  task automatic t_basic;
    enq(1, 16'hA001, 64, 1, "R2 accept");
    enq(1, 16'hA002, 128, 1, "R2 accept");
    enq(2, 16'hB001, 200, 1, "R11 other vl");
    tick(1);
    chk("R5 valid", tx_valid, 1);
    repeat (3) @(negedge clk);
    serve(1, 16'hA001, 64, "R6 hold R5 head");
    tick(1);
    serve(1, 16'hA002, 128, "R4 second");
    tick(1);
    chk("R11 no cross", tx_valid, 0);
    chk("R7 miss vl1", miss(1), 1);
    tick(2);
    serve(2, 16'hB001, 200, "R11 vl2");
  endtask

  task automatic t_full;
    load(2, 0, 4, 7);
    chk("R10 miss clear", miss(1), 0);
    enq(0, 16'hC001, 10, 1, "R2 depth2");
    enq(0, 16'hC002, 11, 1, "R2 depth2");
    enq(0, 16'hC003, 12, 0, "R3 full");
    enq(1, 16'hD001, 13, 0, "R3 depth0");
    for (int i = 0; i < 4; i++) enq(3, 16'hE000 + i, 20 + i, 1, "R10 clamp accept");
    enq(3, 16'hE0FF, 30, 0, "R10 clamp reject");
    tick(0); serve(0, 16'hC001, 10, "R3 unchanged");
    tick(0); serve(0, 16'hC002, 11, "R3 unchanged");
    tick(0);
    chk("R3 nothing extra", tx_valid, 0);
    chk("R7 miss vl0", miss(0), 1);
  endtask

  task automatic t_unsync;
    enq(2, 16'hF001, 99, 1, "R2 vl2");
    sync_ok = 0;
    tick(2);
    chk("R8 no tx", tx_valid, 0);
    tick(1);
    chk("R8 no miss", miss(1), 0);
    sync_ok = 1;
    tick(2);
    chk("R8 resumes", tx_valid, 1);
  endtask

  task automatic t_busy;
    tick(3);
    chk("R9 held vl", {tx_valid, 14'd0, tx_vl, tx_addr}, {1'b1, 14'd0, 2'd2, 16'hF001});
    chk("R9 miss vl3", miss(3), 1);
    serve(2, 16'hF001, 99, "R9 intact");
    tick(3);
    serve(3, 16'hE000, 20, "R9 vl3 queue intact");
  endtask

  task automatic t_sat;
    for (int i = 0; i < 260; i++) tick(1);
    chk("R7 saturate", miss(1), 255);
  endtask

  task automatic t_cfg;
    tick(3);
    chk("R10 pending", tx_valid, 1);
    load(4, 4, 4, 4);
    chk("R10 drop", tx_valid, 0);
    chk("R10 clear counters", miss_count, 0);
    tick(3);
    chk("R10 queue emptied", tx_valid, 0);
    chk("R10 miss after clear", miss(3), 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_full();
        t_unsync();
        t_busy();
        t_sat();
        t_cfg();
      end
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule